// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave end of a three-line serial link. A host uses it to read and write a bank of sixteen 4-bit registers through a chip-enable line, a shift clock and one shared data line. All three inputs are brought into a faster system clock domain through synchronizer chains. Edges of the shift clock are detected in that domain, so the block keeps no logic on the serial clock.

Traffic comes in 8-bit frames. Each frame holds four control bits followed by a 4-bit payload, and the host sends it most significant bit first. The control bits choose among four actions: load the internal address register, write the payload to the addressed register, start a read, or do nothing. After a read command, the block takes over the data line part-way through the next frame and shifts out the addressed nibble. It gives the line back at the start of the frame that follows, which is decoded as a new command. Reads and writes can therefore be chained for as long as chip enable stays high.

The register bank itself lives outside the block. The block presents the current address and takes back the stored nibble. For each write it issues a one-cycle strobe that carries the address and the data.

Top module: `tw_serial_slave`

## Requirements
- R1: After reset the data line is not driven (`sio_oe_o`=0), `wr_en_o` is 0 and the address register (`rd_addr_o`) is 0.
- R2: A frame is 8 bits sampled on shift-clock rising edges, MSB first. Frame bit 7 is ignored. Bit 6 is the read flag (1 = read), bit 5 is the address flag and bit 4 is the data flag. Bits 3..0 are the payload.
- R3: A frame with address flag 1 and data flag 0 loads its payload into the address register, whatever the read flag is. Every other combination leaves the address register unchanged.
- R4: A frame with data flag 1 and both other flags 0 produces exactly one cycle of `wr_en_o`, with `wr_addr_o` equal to the address register and `wr_data_o` equal to the payload. No other combination produces a strobe.
- R5: After a frame with read=1, address=1 and data=0, the next frame is a read-data frame. The data line stays undriven up to its falling edge of clock 2 and is driven from that edge on.
- R6: In the read-data frame, the nibble at the just-loaded address appears on `sio_o` as bit 3, bit 2, bit 1 and bit 0, set on the falling edges of clocks 5, 6, 7 and 8.
- R7: Input bits of the read-data frame are ignored: no strobe and no address change. The data line is released on the falling edge of clock 1 of the next frame, and that next frame is decoded as a new command.
- R8: When chip enable goes low, any partial frame is discarded, the bit counter restarts and the data line is released. The next full frame after chip enable rises again decodes normally.
- R9: A frame whose read, address and data flags are all 0 changes nothing: no strobe and no address change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the shift clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Serial chip enable, active high |
| sck_i | input | 1 | Serial shift clock |
| sio_i | input | 1 | Data line as seen at the pad input |
| sio_o | output | 1 | Data line output value |
| sio_oe_o | output | 1 | Data line output enable (1 = drive) |
| rd_addr_o | output | ADDR_W | Current address register, selects the read nibble |
| rd_data_i | input | DATA_W | Stored nibble at `rd_addr_o` |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | ADDR_W | Write address qualified by `wr_en_o` |
| wr_data_o | output | DATA_W | Write data qualified by `wr_en_o` |

## Verification
The assertions watch four things on every cycle. The write strobe is a single cycle and always follows a completed frame. The address register moves only when a frame completes. The data line is released once chip enable is low. The line's output enable and its value change only just after a detected falling edge of the shift clock.

Several properties need whole frame sequences and so are left to the bench scenarios. These are the exact clock on which the line turns around, the order of the shifted nibble, the fact that read-data frame bits are ignored, the discarding of partial frames, and the flag decoding across every combination, including the ignored leading bit.

// File: rtl/tw_pkg.sv
package tw_pkg;
   localparam int TW_CTRL_W = 4;

   // control nibble, first-sent bit at the top
   typedef struct packed {
      logic spare;   // ignored leading bit
      logic rd;      // 1 = read
      logic adr;     // address-load flag
      logic dat;     // data-write flag
   } tw_ctrl_t;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("tw_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tw_frame_rx.sv
module tw_frame_rx #(
   parameter int FRAME_LEN = 8,
   localparam int CW = $clog2(FRAME_LEN)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ce,
   input  logic                 rise,
   input  logic                 din,
   output logic                 frame_done,
   output logic [FRAME_LEN-1:0] word,
   output logic [CW-1:0]        bit_cnt
);
   logic [FRAME_LEN-2:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt    <= '0;
         shreg      <= '0;
         word       <= '0;
         frame_done <= 1'b0;
      end else begin
         frame_done <= 1'b0;
         if (!ce) begin
            bit_cnt <= '0;
         end else if (rise) begin
            shreg <= {shreg[FRAME_LEN-3:0], din};
            if (bit_cnt == CW'(FRAME_LEN-1)) begin
               bit_cnt    <= '0;
               word       <= {shreg, din};
               frame_done <= 1'b1;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/tw_rd_drv.sv
module tw_rd_drv #(
   parameter int DATA_W    = 4,
   parameter int FRAME_LEN = 8,
   parameter int OE_CLK    = 2,
   localparam int CW       = $clog2(FRAME_LEN),
   localparam int FIRST    = FRAME_LEN - DATA_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic              fall,
   input  logic [CW-1:0]     bit_cnt,
   input  logic              in_data,
   input  logic              data_end,
   input  logic [DATA_W-1:0] rd_data,
   output logic              sio_o,
   output logic              sio_oe
);
   generate
      if (OE_CLK >= FIRST || OE_CLK < 1) begin : g_bad
         $error("tw_rd_drv: turn-around clock must precede the data");
      end
   endgenerate

   logic              tail;
   logic [DATA_W-1:0] snap;
   logic              shift_now;

   // clocks FIRST..FRAME_LEN-1 of the data frame, then clock FRAME_LEN (count wrapped)
   assign shift_now = (in_data && bit_cnt >= CW'(FIRST)) || (tail && bit_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sio_oe <= 1'b0;
         sio_o  <= 1'b0;
         tail   <= 1'b0;
         snap   <= '0;
      end else if (!ce) begin
         sio_oe <= 1'b0;
         tail   <= 1'b0;
      end else begin
         if (data_end) tail <= 1'b1;
         if (fall) begin
            if (in_data && bit_cnt == CW'(OE_CLK)) begin
               sio_oe <= 1'b1;
               snap   <= rd_data;
            end
            if (shift_now) begin
               sio_o <= snap[DATA_W-1];
               snap  <= snap << 1;
            end
            if (tail && bit_cnt == CW'(1)) begin
               sio_oe <= 1'b0;
               tail   <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/tw_serial_slave.sv
module tw_serial_slave
   import tw_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int OE_CLK      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_i,
   input  logic              sck_i,
   input  logic              sio_i,
   output logic              sio_o,
   output logic              sio_oe_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o
);
   localparam int FRAME_LEN = TW_CTRL_W + DATA_W;
   localparam int CW        = $clog2(FRAME_LEN);

   generate
      if (ADDR_W != DATA_W) begin : g_bad
         $error("tw_serial_slave: address and data payloads share one field");
      end
   endgenerate

   logic ce_s, sck_s, sio_s, sck_q;
   logic sck_rise, sck_fall;

   tw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({ce_i, sck_i, sio_i}),
      .q({ce_s, sck_s, sio_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= sck_s;
   end

   assign sck_rise = ce_s &  sck_s & ~sck_q;
   assign sck_fall = ce_s & ~sck_s &  sck_q;

   logic                 frame_done;
   logic [FRAME_LEN-1:0] word;
   logic [CW-1:0]        bit_cnt;

   tw_frame_rx #(.FRAME_LEN(FRAME_LEN)) u_rx (
      .clk(clk), .rst_n(rst_n), .ce(ce_s), .rise(sck_rise), .din(sio_s),
      .frame_done(frame_done), .word(word), .bit_cnt(bit_cnt)
   );

   tw_ctrl_t          ctl;
   logic [DATA_W-1:0] payload;
   logic              unused_spare;
   assign ctl          = word[FRAME_LEN-1 -: TW_CTRL_W];
   assign payload      = word[DATA_W-1:0];
   assign unused_spare = ctl.spare;

   logic in_data, data_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_addr_o <= '0;
         in_data   <= 1'b0;
         data_end  <= 1'b0;
         wr_en_o   <= 1'b0;
         wr_addr_o <= '0;
         wr_data_o <= '0;
      end else begin
         wr_en_o  <= 1'b0;
         data_end <= 1'b0;
         if (!ce_s) begin
            in_data <= 1'b0;
         end else if (frame_done) begin
            if (in_data) begin
               in_data  <= 1'b0;
               data_end <= 1'b1;
            end else begin
               if (ctl.adr && !ctl.dat) rd_addr_o <= payload;
               if (ctl.rd && ctl.adr && !ctl.dat) in_data <= 1'b1;
               if (ctl.dat && !ctl.rd && !ctl.adr) begin
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= rd_addr_o;
                  wr_data_o <= payload;
               end
            end
         end
      end
   end

   tw_rd_drv #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .OE_CLK(OE_CLK)) u_drv (
      .clk(clk), .rst_n(rst_n), .ce(ce_s), .fall(sck_fall), .bit_cnt(bit_cnt),
      .in_data(in_data), .data_end(data_end), .rd_data(rd_data_i),
      .sio_o(sio_o), .sio_oe(sio_oe_o)
   );
endmodule

// File: rtl/tw_serial_slave_chk.sv
module tw_serial_slave_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_s,
   input logic              sck_fall,
   input logic              frame_done,
   input logic              sio_o,
   input logic              sio_oe_o,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic              wr_en_o
);
   assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> !wr_en_o);

   assert_strobe_after_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> $past(frame_done));

   assert_addr_on_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_done |=> $stable(rd_addr_o));

   assert_release_on_ce_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_s |=> !sio_oe_o);

   assert_drive_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sio_oe_o) |-> $past(sck_fall));

   assert_bit_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !sck_fall |=> $stable(sio_o));
endmodule

bind tw_serial_slave tw_serial_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .sck_fall(sck_fall),
   .frame_done(frame_done), .sio_o(sio_o), .sio_oe_o(sio_oe_o),
   .rd_addr_o(rd_addr_o), .wr_en_o(wr_en_o)
);

// File: tb/tb_tw_serial_slave.sv
module tb_tw_serial_slave;
   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce = 1'b0, sck = 1'b0, sin = 1'b0;
   logic sio_o, sio_oe;
   logic [3:0] rd_addr, wr_addr, wr_data, rd_data;
   logic wr_en;

   always #2 clk = ~clk;   // 250 MHz

   tw_serial_slave dut (
      .clk(clk), .rst_n(rst_n), .ce_i(ce), .sck_i(sck), .sio_i(sin),
      .sio_o(sio_o), .sio_oe_o(sio_oe), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
      .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
   );

   // register bank model behind the port
   logic [3:0] mem [16];
   int wr_cnt;
   logic [3:0] last_wa, last_wd;
   assign rd_data = mem[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) mem[i] <= '0;
         wr_cnt <= 0; last_wa <= '0; last_wd <= '0;
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
         wr_cnt  <= wr_cnt + 1;
         last_wa <= wr_addr;
         last_wd <= wr_data;
      end
   end

   int total = 0, bad = 0;
   logic [3:0] exp_mem [16];
   logic [3:0] exp_addr;
   int exp_wr;
   logic obs_oe [1:8];
   logic obs_o  [1:8];
   logic t_oe, t_o;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // one serial bit: falling edge, data set, sample late in low phase, rising edge
   task automatic clk_bit(input logic b);
      sck = 1'b0; sin = b;
      wait_clk(HALF);
      t_oe = sio_oe; t_o = sio_o;
      sck = 1'b1;
      wait_clk(HALF);
   endtask

   task automatic send_frame(input logic [7:0] f);
      for (int i = 7; i >= 0; i--) begin
         clk_bit(f[i]);
         obs_oe[8-i] = t_oe;
         obs_o[8-i]  = t_o;
      end
   endtask

   task automatic ce_low();
      sck = 1'b0; ce = 1'b0;
      wait_clk(2*HALF);
   endtask

   task automatic ce_high();
      sck = 1'b0; ce = 1'b1;
      wait_clk(2*HALF);
   endtask

   function automatic logic [7:0] fr(input logic sp, rd, ad, dt, input logic [3:0] p);
      return {sp, rd, ad, dt, p};
   endfunction

   task automatic do_write(input logic [3:0] a, input logic [3:0] d);
      send_frame(fr($urandom%2, 1'b0, 1'b1, 1'b0, a));
      send_frame(fr($urandom%2, 1'b0, 1'b0, 1'b1, d));
      exp_addr = a; exp_mem[a] = d; exp_wr++;
   endtask

   // read with turn-around checks; data-frame input bits given by dfr
   task automatic do_read(input logic [3:0] a, input logic [7:0] dfr, output logic [3:0] nib);
      send_frame(fr($urandom%2, 1'b1, 1'b1, 1'b0, a));
      exp_addr = a;
      send_frame(dfr);
      chk(obs_oe[2] == 1'b0, "R5 undriven before clock 2 fall", obs_oe[2], 0);
      chk(obs_oe[3] == 1'b1 && obs_oe[8] == 1'b1, "R5 driven from clock 2 fall",
          {obs_oe[3], obs_oe[8]}, 3);
      sck = 1'b0;
      wait_clk(HALF);
      nib = {obs_o[6], obs_o[7], obs_o[8], sio_o};
      chk(sio_oe == 1'b1, "R6 still driven after clock 8 fall", sio_oe, 1);
   endtask

   logic [3:0] nib;
   int w0;

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 16; i++) exp_mem[i] = '0;
      exp_addr = '0; exp_wr = 0;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(3);

      // R1 reset state
      chk(sio_oe == 1'b0, "R1 oe after reset", sio_oe, 0);
      chk(wr_en == 1'b0, "R1 strobe after reset", wr_en, 0);
      chk(rd_addr == 4'h0, "R1 address after reset", rd_addr, 0);

      ce_high();
      // R2 leading bit set to 1 must be ignored
      send_frame(fr(1'b1, 1'b0, 1'b1, 1'b0, 4'hA));
      send_frame(fr(1'b1, 1'b0, 1'b0, 1'b1, 4'h5));
      exp_addr = 4'hA; exp_mem[4'hA] = 4'h5; exp_wr++;
      chk(wr_cnt == exp_wr, "R4 one strobe per write frame", wr_cnt, exp_wr);
      chk(last_wa == 4'hA && last_wd == 4'h5, "R2 R4 strobe address and data",
          {last_wa, last_wd}, 8'hA5);
      chk(rd_addr == 4'hA, "R3 address loaded", rd_addr, 4'hA);

      // R6 read back, then R7 chained address frame releases the line
      do_read(4'hA, 8'h00, nib);
      chk(nib == 4'h5, "R6 read nibble", nib, 5);
      send_frame(fr(1'b0, 1'b0, 1'b1, 1'b0, 4'h3));
      chk(obs_oe[1] == 1'b1 && obs_oe[2] == 1'b0, "R7 release on clock 1 fall",
          {obs_oe[1], obs_oe[2]}, 2);
      chk(rd_addr == 4'h3, "R7 following frame decoded", rd_addr, 3);
      exp_addr = 4'h3;

      // R3 address flag with data flag set: no load
      w0 = wr_cnt;
      send_frame(fr(1'b0, 1'b0, 1'b1, 1'b1, 4'h7));
      chk(rd_addr == 4'h3, "R3 no load when data flag set", rd_addr, 3);
      // R4 read+data flags: no strobe
      send_frame(fr(1'b0, 1'b1, 1'b0, 1'b1, 4'h9));
      chk(wr_cnt == w0, "R4 no strobe with read flag", wr_cnt, w0);
      // R9 terminator frame
      send_frame(8'h00);
      chk(wr_cnt == w0 && rd_addr == 4'h3, "R9 terminator frame inert",
          wr_cnt - w0, 0);

      // R7 read-data frame bits shaped like a write are ignored
      do_read(4'h3, fr(1'b0, 1'b0, 1'b0, 1'b1, 4'hF), nib);
      chk(nib == 4'h0, "R6 read unwritten register", nib, 0);
      chk(wr_cnt == w0 && rd_addr == 4'h3, "R7 data frame input ignored",
          wr_cnt - w0, 0);
      ce_low();

      // R8 partial frame discarded
      ce_high();
      for (int i = 0; i < 5; i++) clk_bit(1'b1);
      ce_low();
      chk(rd_addr == 4'h3, "R8 partial frame no effect", rd_addr, 3);
      ce_high();
      do_write(4'h2, 4'hC);
      chk(wr_cnt == exp_wr && last_wa == 4'h2 && last_wd == 4'hC,
          "R8 frame after reopen decodes", {last_wa, last_wd}, 8'h2C);

      // R8 chip enable dropped inside a read-data frame
      send_frame(fr(1'b0, 1'b1, 1'b1, 1'b0, 4'h2));
      exp_addr = 4'h2;
      for (int i = 0; i < 4; i++) clk_bit(1'b0);
      chk(t_oe == 1'b1, "R5 driven mid data frame", t_oe, 1);
      ce_low();
      chk(sio_oe == 1'b0, "R8 release on chip enable low", sio_oe, 0);
      ce_high();
      do_read(4'h2, 8'hFF, nib);
      chk(nib == 4'hC, "R6 read after reopen", nib, 12);

      // constrained random mix
      for (int it = 0; it < 60; it++) begin
         int op;
         logic [3:0] a, d;
         logic [7:0] b;
         op = $urandom % 4;
         a = 4'($urandom); d = 4'($urandom);
         case (op)
            0: begin
               do_write(a, d);
               chk(wr_cnt == exp_wr && last_wa == a && last_wd == d,
                   "R4 random write", {last_wa, last_wd}, {a, d});
            end
            1: begin
               do_read(a, 8'($urandom), nib);
               chk(nib == exp_mem[a], "R6 random read", nib, exp_mem[a]);
            end
            2: begin
               b = 8'($urandom);
               if (b[6] && b[5] && !b[4]) b[5] = 1'b0;
               send_frame(b);
               if (b[5] && !b[4]) exp_addr = b[3:0];
               if (b[4] && !b[6] && !b[5]) begin
                  exp_mem[exp_addr] = b[3:0]; exp_wr++;
               end
               chk(rd_addr == exp_addr, "R3 random frame address", rd_addr, exp_addr);
               chk(wr_cnt == exp_wr, "R4 R9 random frame strobes", wr_cnt, exp_wr);
            end
            default: begin
               int n;
               n = 1 + ($urandom % 7);
               for (int k = 0; k < n; k++) clk_bit(1'($urandom));
               ce_low();
               ce_high();
               chk(rd_addr == exp_addr && wr_cnt == exp_wr, "R8 random partial frame",
                   rd_addr, exp_addr);
            end
         endcase
         if (op == 1) begin
            ce_low();
            ce_high();
         end
      end

      for (int i = 0; i < 16; i++)
         chk(mem[i] == exp_mem[i], "R4 final register contents", mem[i], exp_mem[i]);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule